// File: doc/BRIEF.md
# Reset Controller with Sticky Cause Flags

This block combines the chip's reset sources into one system reset: an active-low external master-clear pin, a power-on event strobe, a brown-out detect level and a watchdog reset request. The master-clear pin is synchronized and passed through a noise filter, so that only a low level held for a set number of clocks resets the chip. The block only reads that pin and never drives it. After a power-on event, and again once a brown-out has cleared, a power-up timer keeps the system in reset for a fixed number of clocks. If the supply drops again while the timer is counting, the timer starts over.

Two sticky flags record the cause of the last reset. The power-on flag is cleared by a power-on event and by nothing else in hardware. The brown-out flag is cleared by a power-on event and by a brown-out. Only software sets either flag to 1. Firmware writes both flags to 1 after it starts. Later, a brown-out flag of 0 with a power-on flag of 1 points to a brown-out. A strap input disables brown-out detection entirely.

Top module: `rst_ctrl`

## Requirements
- R1: With `mclr_n` held low, `sys_rst` rises after the low level has been seen on FILT_CYCLES consecutive clocks once past the two-flop synchronizer. Counting from the first clock edge that samples the low, this is edge FILT_CYCLES+2. A low pulse covering fewer edges leaves `sys_rst` low.
- R2: When `mclr_n` returns high, and no other source is active, `sys_rst` falls just after the third clock edge that samples the high level. The power-up timer is not started.
- R3: `wdt_req` high drives `sys_rst` high in the same cycle, without waiting for a clock. `wdt_req` changes neither flag.
- R4: `por_evt` high asynchronously drives `sys_rst` high and sets both flags to 0. After `por_evt` falls, `sys_rst` stays high through PWRT_CYCLES-1 clock edges and falls just after edge PWRT_CYCLES.
- R5: `por_flag` does not change on master-clear, watchdog or brown-out resets. Only a software write can set it to 1.
- R6: With `bor_en`=1, `bor_low`=1 drives `sys_rst` high in the same cycle, and `bor_flag` reads 0 after the next clock edge.
- R7: After `bor_low` falls, `sys_rst` stays high through PWRT_CYCLES-1 clock edges and falls just after edge PWRT_CYCLES.
- R8: If `bor_low` rises again while the power-up timer is counting, the timer restarts. The full PWRT_CYCLES count then runs from the new fall of `bor_low`.
- R9: With `bor_en`=0, `bor_low` has no effect: `sys_rst` stays low and `bor_flag` keeps its value. A power-on event still clears `bor_flag`.
- R10: A write with `sw_we`=1 while `sys_rst` is low loads `sw_wdata[0]` into `por_flag` and `sw_wdata[1]` into `bor_flag` at the next clock edge. The write is ignored while `sys_rst` is high, so a brown-out clear in the same cycle wins over a write of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| mclr_n | input | 1 | External master-clear pin, active low, asynchronous |
| por_evt | input | 1 | Power-on event, active high; also resets the block's own state |
| bor_low | input | 1 | Supply-below-threshold level from the brown-out detector |
| bor_en | input | 1 | Strap that enables brown-out detection |
| wdt_req | input | 1 | Watchdog reset request |
| sw_we | input | 1 | Software write strobe for the flags |
| sw_wdata | input | 2 | Write data: bit 0 power-on flag, bit 1 brown-out flag |
| sys_rst | output | 1 | System reset, active high |
| por_flag | output | 1 | Power-on flag (0 after a power-on event) |
| bor_flag | output | 1 | Brown-out flag (0 after a brown-out or power-on) |

## Verification
The watchdog, brown-out and power-on paths must show `sys_rst` high within the same cycle as their input. The bench checks these a moment after it changes the input, with no clock edge in between. Flag updates and software writes are due at the first clock edge after the stimulus. A master-clear assertion is due at edge FILT_CYCLES+2 and its release at edge 3, because the synchronizer adds two edges. The power-up timer releases `sys_rst` at edge PWRT_CYCLES after the source falls. For each delay the bench samples one edge early to confirm reset is still held and again on the due edge to confirm the change. All samples are taken 1 ns after a rising edge, with inputs changed only at those sample points.

// File: rtl/rst_ctrl.sv
module rst_ctrl #(
  parameter int FILT_CYCLES = 4,
  parameter int PWRT_CYCLES = 64
) (
  input  logic       clk,
  input  logic       mclr_n,
  input  logic       por_evt,
  input  logic       bor_low,
  input  logic       bor_en,
  input  logic       wdt_req,
  input  logic       sw_we,
  input  logic [1:0] sw_wdata,
  output logic       sys_rst,
  output logic       por_flag,
  output logic       bor_flag
);
  localparam int FW = $clog2(FILT_CYCLES + 1);
  localparam int TW = (PWRT_CYCLES > 1) ? $clog2(PWRT_CYCLES) : 1;

  logic [1:0]    mclr_sync;
  logic [FW-1:0] low_cnt;
  logic [TW-1:0] pwrt_cnt;
  logic          pwrt_done;
  logic          mclr_hit;
  logic          bor_act;

  assign bor_act  = bor_en & bor_low;
  assign mclr_hit = (low_cnt == FW'(FILT_CYCLES));
  assign sys_rst  = por_evt | wdt_req | bor_act | mclr_hit | ~pwrt_done;

  always_ff @(posedge clk or posedge por_evt) begin
    if (por_evt) mclr_sync <= 2'b11;
    else         mclr_sync <= {mclr_sync[0], mclr_n};
  end

  always_ff @(posedge clk or posedge por_evt) begin
    if (por_evt)           low_cnt <= '0;
    else if (mclr_sync[1]) low_cnt <= '0;
    else if (!mclr_hit)    low_cnt <= low_cnt + 1'b1;
  end

  always_ff @(posedge clk or posedge por_evt) begin
    if (por_evt) begin
      pwrt_cnt  <= '0;
      pwrt_done <= 1'b0;
    end else if (bor_act) begin
      pwrt_cnt  <= '0;
      pwrt_done <= 1'b0;
    end else if (!pwrt_done) begin
      if (pwrt_cnt == TW'(PWRT_CYCLES - 1)) pwrt_done <= 1'b1;
      else                                  pwrt_cnt  <= pwrt_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or posedge por_evt) begin
    if (por_evt) begin
      por_flag <= 1'b0;
      bor_flag <= 1'b0;
    end else begin
      if (sw_we && !sys_rst) begin
        por_flag <= sw_wdata[0];
        bor_flag <= sw_wdata[1];
      end
      if (bor_act) bor_flag <= 1'b0;
    end
  end
endmodule

// File: rtl/rst_ctrl_chk.sv
module rst_ctrl_chk (
  input logic       clk,
  input logic       por_evt,
  input logic       bor_low,
  input logic       bor_en,
  input logic       wdt_req,
  input logic       sw_we,
  input logic [1:0] sw_wdata,
  input logic       sys_rst,
  input logic       por_flag,
  input logic       bor_flag
);
  AST_WDT_FORCES_RST: assert property (@(posedge clk) disable iff (por_evt)
    wdt_req |-> sys_rst);                                                  // R3
  AST_BOR_CLEARS_FLAG: assert property (@(posedge clk) disable iff (por_evt)
    (bor_en && bor_low) |=> !bor_flag);                                    // R6
  AST_POR_FLAG_SW_ONLY: assert property (@(posedge clk) disable iff (por_evt)
    $rose(por_flag) |-> $past(sw_we && sw_wdata[0]));                      // R5
  AST_BOR_FALL_CAUSE: assert property (@(posedge clk) disable iff (por_evt)
    $fell(bor_flag) |-> $past((bor_en && bor_low) || (sw_we && !sw_wdata[1]))); // R9
  AST_WRITE_BLOCKED: assert property (@(posedge clk) disable iff (por_evt)
    sys_rst |=> $stable(por_flag));                                        // R10
endmodule

bind rst_ctrl rst_ctrl_chk u_chk (.*);

// File: tb/tb_rst_ctrl.sv
`timescale 1ns/1ps
module tb_rst_ctrl;
  localparam int FILT = 4;
  localparam int PWRT = 64;

  logic clk = 0, mclr_n = 1, por_evt = 1, bor_low = 0, bor_en = 1, wdt_req = 0, sw_we = 0;
  logic [1:0] sw_wdata = 0;
  logic sys_rst, por_flag, bor_flag;
  int checks = 0, fails = 0;
  bit finished = 0;

  rst_ctrl #(.FILT_CYCLES(FILT), .PWRT_CYCLES(PWRT)) dut (
    .clk(clk), .mclr_n(mclr_n), .por_evt(por_evt), .bor_low(bor_low), .bor_en(bor_en),
    .wdt_req(wdt_req), .sw_we(sw_we), .sw_wdata(sw_wdata),
    .sys_rst(sys_rst), .por_flag(por_flag), .bor_flag(bor_flag));

  always #10 clk = ~clk;

  // {wdata, expected {bor_flag, por_flag}}
  localparam logic [3:0] WR_VEC [6] = '{4'b11_11, 4'b01_01, 4'b10_10, 4'b00_00, 4'b10_10, 4'b11_11};

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic write_flags(input logic [1:0] d);
    sw_we = 1; sw_wdata = d;
    step(1);
    sw_we = 0;
  endtask

  initial begin
    #5;
    chk("R4 reset sys_rst", sys_rst, 1);
    chk("R4 reset flags", {bor_flag, por_flag}, 2'b00);
    step(2);
    por_evt = 0;
    step(PWRT - 1);
    chk("R4 timer hold", sys_rst, 1);
    step(1);
    chk("R4 timer release", sys_rst, 0);

    for (int i = 0; i < 6; i++) begin
      write_flags(WR_VEC[i][3:2]);
      chk("R10 write vector", {bor_flag, por_flag}, WR_VEC[i][1:0]);
    end

    mclr_n = 0;
    step(FILT - 1);
    mclr_n = 1;
    step(FILT + 3);
    chk("R1 short pulse ignored", sys_rst, 0);
    mclr_n = 0;
    step(FILT + 1);
    chk("R1 filter not yet", sys_rst, 0);
    step(1);
    chk("R1 filter assert", sys_rst, 1);
    mclr_n = 1;
    step(2);
    chk("R2 release hold", sys_rst, 1);
    step(1);
    chk("R2 release", sys_rst, 0);
    chk("R5 mclr keeps flags", {bor_flag, por_flag}, 2'b11);

    wdt_req = 1; #1;
    chk("R3 wdt immediate", sys_rst, 1);
    sw_we = 1; sw_wdata = 2'b00;
    step(2);
    sw_we = 0;
    chk("R3 wdt keeps flags", {bor_flag, por_flag}, 2'b11);
    chk("R10 write ignored in reset", {bor_flag, por_flag}, 2'b11);
    wdt_req = 0; #1;
    chk("R3 wdt release", sys_rst, 0);

    bor_low = 1; sw_we = 1; sw_wdata = 2'b11; #1;
    chk("R6 bor immediate", sys_rst, 1);
    step(1);
    sw_we = 0;
    chk("R6 bor clears flag", bor_flag, 0);
    chk("R10 clear beats write", por_flag, 1);
    bor_low = 0;
    step(PWRT - 1);
    chk("R7 timer hold", sys_rst, 1);
    step(1);
    chk("R7 timer release", sys_rst, 0);
    chk("R5 bor keeps por_flag", por_flag, 1);

    bor_low = 1; step(1); bor_low = 0;
    step(20);
    bor_low = 1; step(1); bor_low = 0;
    step(PWRT - 1);
    chk("R8 restart hold", sys_rst, 1);
    step(1);
    chk("R8 restart release", sys_rst, 0);

    write_flags(2'b11);
    bor_en = 0; bor_low = 1; #1;
    chk("R9 disabled no reset", sys_rst, 0);
    step(3);
    chk("R9 disabled flag kept", bor_flag, 1);
    chk("R9 disabled no reset later", sys_rst, 0);
    bor_low = 0;
    por_evt = 1; #2;
    chk("R9 por clears flags when disabled", {bor_flag, por_flag}, 2'b00);
    chk("R4 por sys_rst", sys_rst, 1);
    step(1);
    por_evt = 0;
    step(PWRT);
    chk("R4 second release", sys_rst, 0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule